// File: doc/BRIEF.md
# Runtime Phase Step Controller

This block holds the live phase codes of four clock output channels and nudges them while the chip runs. Each channel has a coarse code, counted in steps of 1/ratio of a turn, and a fine code, counted in steps of 1/(8×ratio) of a turn. Here ratio is the channel's output divide ratio. The phase-offset dividers downstream read both codes straight from the outputs. At reset every channel loads its static initial codes from configuration inputs. Note that a coarse code of ratio−1 means zero offset.

Software or a calibration engine adjusts the codes in three steps. It picks a channel with a 2-bit select. It sets the direction bit. It then raises the coarse strobe or the fine strobe. Coarse steps move either way. Fine steps only count up, and when the fine code overflows it carries into the coarse code.

A configuration bit turns runtime control on or off. While it is clear, every control input is ignored. No data stream passes through the block, so all pins are plain control and status levels with no valid/ready handshake.

Top module: `phase_step_ctrl`

## Requirements
- R1: `sel_i` (value 0 to 3) picks the one channel a step acts on. The codes of the other three channels do not change.
- R2: A coarse step moves the selected coarse code by one: up when `dir_up_i` is 1, down when it is 0.
- R3: A fine step adds one to the selected fine code, whatever the value of `dir_up_i`.
- R4: Suppose a strobe is first seen high at clock edge k, after being low at edge k−1. The step then appears on the outputs after edge k+1 and not before. `sel_i` and `dir_up_i` are taken at edge k.
- R5: While `dyn_en` is 0, `sel_i`, `dir_up_i` and both strobes have no effect on any code.
- R6: While `rst_n` is 0 at a clock edge (synchronous, active low), each channel loads `init_coarse_i` and `init_fine_i` for that channel.
- R7: A strobe held high for many cycles makes exactly one step. Only a 0-to-1 change counts.
- R8: A coarse code never goes below 0 or above 2×(ratio−1). A step that would cross either bound leaves the code unchanged.
- R9: A fine step at the fine ceiling min(127, 8×ratio−1) sets the fine code to 0 and adds one to the coarse code. This happens only when the coarse code is below 2×(ratio−1).
- R10: A fine step at the fine ceiling while the coarse code is at 2×(ratio−1) leaves both codes unchanged.
- R11: A coarse and a fine rise at the same edge are both applied. The coarse step comes one cycle before the fine step, and no step is lost.
- R12: In any one cycle at most one channel's codes change, and a coarse code moves by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial codes |
| dyn_en | input | 1 | Runtime phase control enable |
| sel_i | input | 2 | Channel to adjust |
| dir_up_i | input | 1 | Coarse direction, 1 = up |
| coarse_stb_i | input | 1 | Coarse step strobe, edge-sensitive |
| fine_stb_i | input | 1 | Fine step strobe, edge-sensitive |
| ratio_i | input | 4×8 | Per-channel divide ratio (1 to 128), channel n at bits [8n+7:8n] |
| init_coarse_i | input | 4×8 | Per-channel initial coarse code |
| init_fine_i | input | 4×7 | Per-channel initial fine code |
| coarse_o | output | 4×8 | Live coarse code per channel |
| fine_o | output | 4×7 | Live fine code per channel |

## Verification
A single strobe rise moves the codes two clock edges after it is first sampled: one edge to capture the request and one to apply it. When a coarse and a fine rise arrive together, the fine result comes one edge later still. The bench drives every input on the falling edge and waits a counted number of falling edges before it compares the outputs. In the latency and coincidence tests it also samples the intermediate falling edges, which shows that no result lands early. Every other step is given three full cycles to settle before it is checked.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;
  localparam int SEL_W  = 2;
  localparam int NCH    = 1 << SEL_W;
  localparam int FINE_W = 7;

  typedef enum logic {
    STEP_COARSE = 1'b0,
    STEP_FINE   = 1'b1
  } step_kind_e;

  typedef struct packed {
    logic             vld;
    step_kind_e       kind;
    logic [SEL_W-1:0] ch;
    logic             up;
  } step_req_t;
endpackage

// File: rtl/phase_rise_det.sv
module phase_rise_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/phase_req_sched.sv
module phase_req_sched
  import phase_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             c_rise_i,
  input  logic             f_rise_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             up_i,
  output step_req_t        req_o
);
  logic             c_pend_q, f_pend_q;
  logic [SEL_W-1:0] c_ch_q, f_ch_q;
  logic             c_up_q;
  logic             cap_c, cap_f;

  assign cap_c = c_rise_i & en_i;
  assign cap_f = f_rise_i & en_i;

  // Coarse requests go first; a fine request waits one cycle behind them.
  always_comb begin
    req_o = '0;
    if (c_pend_q) begin
      req_o.vld  = 1'b1;
      req_o.kind = STEP_COARSE;
      req_o.ch   = c_ch_q;
      req_o.up   = c_up_q;
    end else if (f_pend_q) begin
      req_o.vld  = 1'b1;
      req_o.kind = STEP_FINE;
      req_o.ch   = f_ch_q;
      req_o.up   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_pend_q <= 1'b0;
      f_pend_q <= 1'b0;
      c_ch_q   <= '0;
      f_ch_q   <= '0;
      c_up_q   <= 1'b0;
    end else begin
      c_pend_q <= cap_c;
      f_pend_q <= cap_f | (f_pend_q & c_pend_q);
      if (cap_c) begin
        c_ch_q <= sel_i;
        c_up_q <= up_i;
      end
      if (cap_f) f_ch_q <= sel_i;
    end
  end
endmodule

// File: rtl/phase_chan_codes.sv
module phase_chan_codes
  import phase_step_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CW    = 8,
  parameter int FW    = FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic [CW-1:0]    init_c_i,
  input  logic [FW-1:0]    init_f_i,
  input  logic             hit_i,
  input  step_kind_e       kind_i,
  input  logic             up_i,
  output logic [CW-1:0]    coarse_q,
  output logic [FW-1:0]    fine_q
);
  localparam int EW = DIV_W + CW + 4;
  localparam logic [EW-1:0] ONE_E   = EW'(1);
  localparam logic [EW-1:0] FABS_E  = EW'((1 << FW) - 1);

  logic [EW-1:0] r_e, cmax_e, fcap_e, fmax_e, c_e, f_e;
  logic          up_ok, dn_ok, f_top;

  assign r_e    = EW'(ratio_i);
  assign cmax_e = (r_e - ONE_E) << 1;
  assign fcap_e = (r_e << 3) - ONE_E;
  assign fmax_e = (fcap_e > FABS_E) ? FABS_E : fcap_e;
  assign c_e    = EW'(coarse_q);
  assign f_e    = EW'(fine_q);
  assign up_ok  = c_e < cmax_e;
  assign dn_ok  = coarse_q != '0;
  assign f_top  = f_e >= fmax_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= init_c_i;
      fine_q   <= init_f_i;
    end else if (hit_i) begin
      if (kind_i == STEP_COARSE) begin
        if (up_i && up_ok)       coarse_q <= coarse_q + 1'b1;
        else if (!up_i && dn_ok) coarse_q <= coarse_q - 1'b1;
      end else if (!f_top) begin
        fine_q <= fine_q + 1'b1;
      end else if (up_ok) begin
        fine_q   <= '0;
        coarse_q <= coarse_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter int MAX_RATIO = 128,
  localparam int DIV_W    = $clog2(MAX_RATIO + 1),
  localparam int CW       = $clog2(2 * MAX_RATIO - 1),
  localparam int FW       = FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dyn_en,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                dir_up_i,
  input  logic                coarse_stb_i,
  input  logic                fine_stb_i,
  input  logic [NCH*DIV_W-1:0] ratio_i,
  input  logic [NCH*CW-1:0]   init_coarse_i,
  input  logic [NCH*FW-1:0]   init_fine_i,
  output logic [NCH*CW-1:0]   coarse_o,
  output logic [NCH*FW-1:0]   fine_o
);
  logic [1:0] rise;
  step_req_t  req;

  phase_rise_det #(.W(2)) rise_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({fine_stb_i, coarse_stb_i}),
    .rise_o (rise)
  );

  phase_req_sched sched_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (dyn_en),
    .c_rise_i (rise[0]),
    .f_rise_i (rise[1]),
    .sel_i    (sel_i),
    .up_i     (dir_up_i),
    .req_o    (req)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = req.vld && (req.ch == SEL_W'(g));

    phase_chan_codes #(.DIV_W(DIV_W), .CW(CW), .FW(FW)) codes_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio_i  (ratio_i[g*DIV_W +: DIV_W]),
      .init_c_i (init_coarse_i[g*CW +: CW]),
      .init_f_i (init_fine_i[g*FW +: FW]),
      .hit_i    (hit),
      .kind_i   (req.kind),
      .up_i     (req.up),
      .coarse_q (coarse_o[g*CW +: CW]),
      .fine_q   (fine_o[g*FW +: FW])
    );
  end
endmodule

// File: rtl/phase_step_ctrl_chk.sv
module phase_step_ctrl_chk
  import phase_step_pkg::*;
#(
  parameter int MAX_RATIO = 128,
  localparam int DIV_W    = $clog2(MAX_RATIO + 1),
  localparam int CW       = $clog2(2 * MAX_RATIO - 1),
  localparam int FW       = FINE_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dyn_en,
  input logic [NCH*DIV_W-1:0] ratio_i,
  input logic [NCH*CW-1:0]    coarse_o,
  input logic [NCH*FW-1:0]    fine_o
);
  logic [NCH*CW-1:0] c_prev;
  logic [NCH*FW-1:0] f_prev;
  logic              prev_ok, en_d1, en_d2, en_d3;
  logic [NCH-1:0]    chg;

  always_ff @(posedge clk) begin
    c_prev <= coarse_o;
    f_prev <= fine_o;
    if (!rst_n) begin
      prev_ok <= 1'b0;
      en_d1   <= 1'b1;
      en_d2   <= 1'b1;
      en_d3   <= 1'b1;
    end else begin
      prev_ok <= 1'b1;
      en_d1   <= dyn_en;
      en_d2   <= en_d1;
      en_d3   <= en_d2;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_c
    logic [CW+1:0] r_x, c_x, p_x;
    logic [FW+3:0] fcap;
    assign r_x  = (CW+2)'(ratio_i[g*DIV_W +: DIV_W]);
    assign c_x  = (CW+2)'(coarse_o[g*CW +: CW]);
    assign p_x  = (CW+2)'(c_prev[g*CW +: CW]);
    assign fcap = ((FW+4)'(ratio_i[g*DIV_W +: DIV_W]) << 3) - 1'b1;
    assign chg[g] = (c_x != p_x) || (fine_o[g*FW +: FW] != f_prev[g*FW +: FW]);

    a_r8_coarse_range: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> c_x <= ((r_x - 1'b1) << 1));
    a_r9_fine_range: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> (FW+4)'(fine_o[g*FW +: FW]) <= fcap);
    a_r12_coarse_unit: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> ((c_x > p_x) ? (c_x - p_x) : (p_x - c_x)) <= 1);
  end

  a_r12_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> $countones(chg) <= 1);
  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && !en_d2 && !en_d3) |-> chg == '0);
endmodule

bind phase_step_ctrl phase_step_ctrl_chk #(.MAX_RATIO(MAX_RATIO)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .dyn_en   (dyn_en),
  .ratio_i  (ratio_i),
  .coarse_o (coarse_o),
  .fine_o   (fine_o)
);

// File: tb/phase_step_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_step_ctrl_tb_top;
  localparam int MAX_RATIO = 128;
  localparam int NCH   = 4;
  localparam int DIV_W = $clog2(MAX_RATIO + 1);
  localparam int CW    = $clog2(2 * MAX_RATIO - 1);
  localparam int FW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dyn_en = 1'b1;
  logic [1:0] sel_i = '0;
  logic dir_up_i = 1'b0;
  logic coarse_stb_i = 1'b0;
  logic fine_stb_i = 1'b0;
  logic [NCH*DIV_W-1:0] ratio_i;
  logic [NCH*CW-1:0] init_coarse_i;
  logic [NCH*FW-1:0] init_fine_i;
  logic [NCH*CW-1:0] coarse_o;
  logic [NCH*FW-1:0] fine_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int ratio[NCH] = '{8, 1, 3, 20};
  int exp_c[NCH] = '{7, 0, 2, 19};
  int exp_f[NCH] = '{0, 5, 22, 126};

  always #4 clk = ~clk;

  phase_step_ctrl #(.MAX_RATIO(MAX_RATIO)) dut_i (
    .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en), .sel_i(sel_i),
    .dir_up_i(dir_up_i), .coarse_stb_i(coarse_stb_i), .fine_stb_i(fine_stb_i),
    .ratio_i(ratio_i), .init_coarse_i(init_coarse_i), .init_fine_i(init_fine_i),
    .coarse_o(coarse_o), .fine_o(fine_o)
  );

  function automatic int cmax(int ch); return 2 * (ratio[ch] - 1); endfunction
  function automatic int fmax(int ch);
    return (8 * ratio[ch] - 1 > 127) ? 127 : 8 * ratio[ch] - 1;
  endfunction

  function automatic void model_coarse(int ch, bit up);
    if (up && exp_c[ch] < cmax(ch)) exp_c[ch]++;
    else if (!up && exp_c[ch] > 0) exp_c[ch]--;
  endfunction

  function automatic void model_fine(int ch);
    if (exp_f[ch] < fmax(ch)) exp_f[ch]++;
    else if (exp_c[ch] < cmax(ch)) begin exp_f[ch] = 0; exp_c[ch]++; end
  endfunction

  task automatic check_codes(string tag);
    bit bad = 0;
    n_checks++;
    for (int i = 0; i < NCH; i++) begin
      if (int'(coarse_o[i*CW +: CW]) != exp_c[i] || int'(fine_o[i*FW +: FW]) != exp_f[i]) begin
        $display("FAIL %s ch%0d: actual coarse=%0d fine=%0d expected coarse=%0d fine=%0d",
                 tag, i, coarse_o[i*CW +: CW], fine_o[i*FW +: FW], exp_c[i], exp_f[i]);
        bad = 1;
      end
    end
    if (bad) n_fail++;
  endtask

  // One strobe pulse held for 'hold' cycles, then three settle cycles.
  task automatic step(bit fine, int ch, bit up, int hold);
    @(negedge clk);
    sel_i = 2'(ch);
    dir_up_i = up;
    if (fine) fine_stb_i = 1'b1; else coarse_stb_i = 1'b1;
    repeat (hold) @(negedge clk);
    fine_stb_i = 1'b0;
    coarse_stb_i = 1'b0;
    repeat (3) @(negedge clk);
    if (dyn_en) begin
      if (fine) model_fine(ch); else model_coarse(ch, up);
    end
  endtask

  task automatic t_reset;
    check_codes("R6 reset load");
  endtask

  task automatic t_latency;
    @(negedge clk);
    sel_i = 2'd0; dir_up_i = 1'b1; coarse_stb_i = 1'b1;
    @(negedge clk);
    coarse_stb_i = 1'b0;
    check_codes("R4 no change one edge after rise");
    @(negedge clk);
    model_coarse(0, 1'b1);
    check_codes("R4 R2 coarse up after two edges");
    repeat (2) @(negedge clk);
  endtask

  task automatic t_select_dir;
    step(0, 0, 1'b0, 1);
    step(0, 0, 1'b0, 1);
    check_codes("R2 coarse down twice on ch0");
    step(0, 3, 1'b1, 1);
    check_codes("R1 only ch3 moved");
  endtask

  task automatic t_held;
    step(0, 2, 1'b1, 6);
    check_codes("R7 held strobe single step");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 3; k++) step(0, 2, 1'b1, 1);
    check_codes("R8 coarse ceiling");
    step(0, 1, 1'b0, 1);
    check_codes("R8 coarse floor");
    step(0, 1, 1'b1, 1);
    check_codes("R8 ratio one ceiling");
  endtask

  task automatic t_fine;
    step(1, 0, 1'b0, 1);
    check_codes("R3 fine up with dir 0");
    step(1, 0, 1'b1, 1);
    check_codes("R3 fine up with dir 1");
  endtask

  task automatic t_wrap;
    step(1, 3, 1'b0, 1);
    check_codes("R9 fine reaches 127");
    step(1, 3, 1'b0, 1);
    check_codes("R9 fine wraps with carry");
  endtask

  task automatic t_top;
    step(1, 2, 1'b1, 1);
    check_codes("R10 fine to ceiling");
    step(1, 2, 1'b1, 1);
    check_codes("R10 fine at ceiling with coarse at max");
    for (int k = 0; k < 3; k++) step(1, 1, 1'b1, 1);
    check_codes("R10 ratio one fine ceiling");
  endtask

  task automatic t_disabled;
    @(negedge clk); dyn_en = 1'b0;
    step(0, 0, 1'b1, 1);
    step(1, 0, 1'b1, 1);
    step(0, 3, 1'b0, 2);
    check_codes("R5 disabled ignores strobes");
    @(negedge clk); dyn_en = 1'b1;
    repeat (2) @(negedge clk);
    check_codes("R5 re-enable alone changes nothing");
  endtask

  task automatic t_both;
    @(negedge clk);
    sel_i = 2'd0; dir_up_i = 1'b1; coarse_stb_i = 1'b1; fine_stb_i = 1'b1;
    @(negedge clk);
    coarse_stb_i = 1'b0; fine_stb_i = 1'b0;
    @(negedge clk);
    model_coarse(0, 1'b1);
    check_codes("R11 coarse applied first");
    @(negedge clk);
    model_fine(0);
    check_codes("R11 fine applied next cycle");
    repeat (2) @(negedge clk);
    check_codes("R11 nothing lost or repeated");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      ratio_i[i*DIV_W +: DIV_W] = DIV_W'(ratio[i]);
      init_coarse_i[i*CW +: CW] = CW'(exp_c[i]);
      init_fine_i[i*FW +: FW]   = FW'(exp_f[i]);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_select_dir();
    t_held();
    t_saturate();
    t_fine();
    t_wrap();
    t_top();
    t_disabled();
    t_both();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule